// File: doc/BRIEF.md
# Random Tag Generator with Exclusion

This block hands out 4-bit memory-allocation tags. Each accepted request steps a 16-bit linear feedback shift register four times, and the four feedback bits form a random offset. Starting from the tag it produced last time, the block then walks forward modulo 16. On each step it skips any tag whose bit is set in a 16-bit exclusion mask, and it stops on the offset-th allowed tag. The chosen tag is inserted into bits 59:56 of the request pointer and returned on a result stream.

A request pairs a pointer with an operand exclusion mask. A configuration mask is ORed onto the operand mask, and a random-mode enable is also applied. Requests use a valid/ready handshake. The result is held with `res_valid` until `res_ready` is seen high, so a slow consumer back-pressures the block. No new request is taken until the result has left. The seed and the last tag are visible on a 24-bit state port, and that state can be written while the block is idle.

Top module: `tag_rand_gen`

## Requirements
- R1: After reset, `req_ready` is 1, `res_valid` is 0, and `st_rdata` equals 0x000100 (seed 0x0001, tag 0).
- R2: The mask in use is `req_excl | cfg_excl`, sampled when the request is accepted. Tag t counts as excluded when bit t of that mask is 1.
- R3: When all 16 mask bits are 1, the tag produced is 0, whatever the seed and start tag.
- R4: Each request makes four LFSR steps. In each step the feedback bit is seed[5]^seed[3]^seed[2]^seed[0], the seed shifts right by one, and the feedback bit enters at bit 15. The feedback bit of step i (i = 0..3) becomes bit i of the offset.
- R5: With offset 0, the start tag is kept if it is allowed. Otherwise the tag is incremented modulo 16 until an allowed value is reached.
- R6: With a non-zero offset N, the block N times advances modulo 16 to the next allowed tag.
- R7: `st_rdata` holds the tag in bits 3:0, zeros in bits 7:4, and the seed in bits 23:8. After a request these hold the new tag and the stepped seed, and the next request starts from that tag.
- R8: If `rnd_en` is 1 and the seed is 0 at acceptance, the seed 0x0001 is used instead before stepping. If `rnd_en` is 0, a zero seed stays zero and gives offset 0. `rnd_en` has no effect when the seed is non-zero.
- R9: `res_ptr` equals the accepted `req_ptr` with bits 59:56 replaced by the new tag.
- R10: A request is taken on a cycle with `req_valid` and `req_ready` both 1. `req_ready` is 1 only when the block is idle and `st_wr` is 0. `res_valid` stays 1, with `res_ptr` unchanged, until a cycle where `res_ready` is 1.
- R11: `st_wr` while idle loads the seed from `st_wdata[23:8]` and the tag from `st_wdata[3:0]` on that edge. A request raised in the same cycle is not taken. `st_wr` while a request is in progress or its result is waiting is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_ptr | input | 64 | Pointer to receive the tag |
| req_excl | input | 16 | Operand exclusion mask |
| cfg_excl | input | 16 | Configured exclusion mask |
| rnd_en | input | 1 | Random mode; a zero seed is replaced |
| res_valid | output | 1 | Tagged pointer available |
| res_ready | input | 1 | Consumer takes the result |
| res_ptr | output | 64 | Pointer carrying the new tag |
| st_wr | input | 1 | Write the state register |
| st_wdata | input | 24 | State value to write |
| st_rdata | output | 24 | Current state: seed and last tag |

## Verification
A state write and a new request can arrive in the same idle cycle. The bench raises `st_wr` and `req_valid` together and expects `req_ready` low in that cycle. It then checks that the written state shows up and that no result follows. A second collision happens when a state write lands while a walk is running or a result is waiting. The bench pulses `st_wr` at those moments and checks that the state reported alongside the result matches its own model, which ignores the write.

// File: rtl/tag_rand_pkg.sv
package tag_rand_pkg;
  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_WALK = 2'd1,
    S_HOLD = 2'd2
  } rtg_state_e;
endpackage

// File: rtl/rtg_lfsr_steps.sv
// Unrolled chain of LFSR steps; each step's feedback bit is one offset bit.
module rtg_lfsr_steps #(
  parameter int          SEED_W = 16,
  parameter int          NSTEPS = 4,
  parameter logic [15:0] TAPS   = 16'h002D
) (
  input  logic [SEED_W-1:0] seed_in,
  output logic [SEED_W-1:0] seed_out,
  output logic [NSTEPS-1:0] offset
);
  logic [SEED_W-1:0] chain [NSTEPS+1];

  assign chain[0] = seed_in;

  for (genvar i = 0; i < NSTEPS; i++) begin : g_step
    logic fb;
    assign fb           = ^(chain[i] & TAPS[SEED_W-1:0]);
    assign chain[i+1]   = {fb, chain[i][SEED_W-1:1]};
    assign offset[i]    = fb;
  end

  assign seed_out = chain[NSTEPS];
endmodule

// File: rtl/rtg_skip_walker.sv
// One candidate tag per cycle; counts down the offset on allowed tags only.
module rtg_skip_walker #(
  parameter int TAG_W = 4,
  parameter int OFF_W = 4,
  localparam int NTAGS = 1 << TAG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [TAG_W-1:0] start_tag,
  input  logic [OFF_W-1:0] offset,
  input  logic [NTAGS-1:0] excl,
  output logic             fin,
  output logic [TAG_W-1:0] tag_o
);
  logic [TAG_W-1:0] tag_q;
  logic [TAG_W-1:0] tag_nx;
  logic [OFF_W-1:0] rem_q;
  logic [NTAGS-1:0] excl_q;
  logic             act_q;
  logic             fin_q;

  assign tag_nx = tag_q + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tag_q  <= '0;
      rem_q  <= '0;
      excl_q <= '0;
      act_q  <= 1'b0;
      fin_q  <= 1'b0;
    end else begin
      fin_q <= 1'b0;
      if (start) begin
        excl_q <= excl;
        rem_q  <= offset;
        if (&excl) begin
          tag_q <= '0;
          act_q <= 1'b0;
          fin_q <= 1'b1;
        end else begin
          tag_q <= start_tag;
          act_q <= 1'b1;
        end
      end else if (act_q) begin
        if (rem_q == '0 && !excl_q[tag_q]) begin
          act_q <= 1'b0;
          fin_q <= 1'b1;
        end else begin
          tag_q <= tag_nx;
          if (rem_q != '0 && !excl_q[tag_nx]) rem_q <= rem_q - 1'b1;
        end
      end
    end
  end

  assign fin   = fin_q;
  assign tag_o = tag_q;
endmodule

// File: rtl/tag_rand_gen.sv
module tag_rand_gen
  import tag_rand_pkg::*;
#(
  parameter int          PTR_W         = 64,
  parameter int          TAG_W         = 4,
  parameter int          TAG_LSB       = 56,
  parameter int          SEED_W        = 16,
  parameter int          NSTEPS        = 4,
  parameter logic [15:0] TAPS          = 16'h002D,
  parameter logic [15:0] FALLBACK_SEED = 16'h0001,
  parameter logic [15:0] RESET_SEED    = 16'h0001,
  localparam int NTAGS    = 1 << TAG_W,
  localparam int SEED_LSB = 8,
  localparam int ST_W     = SEED_LSB + SEED_W,
  localparam int PAD_W    = SEED_LSB - TAG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [PTR_W-1:0]  req_ptr,
  input  logic [NTAGS-1:0]  req_excl,
  input  logic [NTAGS-1:0]  cfg_excl,
  input  logic              rnd_en,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [PTR_W-1:0]  res_ptr,
  input  logic              st_wr,
  input  logic [ST_W-1:0]   st_wdata,
  output logic [ST_W-1:0]   st_rdata
);
  localparam logic [PTR_W-1:0] TAG_MASK = {{(PTR_W-TAG_W){1'b0}}, {TAG_W{1'b1}}} << TAG_LSB;

  rtg_state_e        state_q;
  logic [SEED_W-1:0] seed_q;
  logic [TAG_W-1:0]  tag_q;
  logic [PTR_W-1:0]  ptr_q;

  logic [SEED_W-1:0] seed_src;
  logic [SEED_W-1:0] seed_step;
  logic [NSTEPS-1:0] offset;
  logic [NTAGS-1:0]  excl_eff;
  logic              accept;
  logic              w_fin;
  logic [TAG_W-1:0]  w_tag;

  assign seed_src  = (rnd_en && seed_q == '0) ? FALLBACK_SEED[SEED_W-1:0] : seed_q;
  assign excl_eff  = req_excl | cfg_excl;
  assign req_ready = (state_q == S_IDLE) && !st_wr;
  assign accept    = req_valid && req_ready;

  rtg_lfsr_steps #(
    .SEED_W (SEED_W),
    .NSTEPS (NSTEPS),
    .TAPS   (TAPS)
  ) u_lfsr (
    .seed_in  (seed_src),
    .seed_out (seed_step),
    .offset   (offset)
  );

  rtg_skip_walker #(
    .TAG_W (TAG_W),
    .OFF_W (NSTEPS)
  ) u_walk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (accept),
    .start_tag (tag_q),
    .offset    (offset),
    .excl      (excl_eff),
    .fin       (w_fin),
    .tag_o     (w_tag)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      seed_q  <= RESET_SEED[SEED_W-1:0];
      tag_q   <= '0;
      ptr_q   <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: begin
          if (st_wr) begin
            seed_q <= st_wdata[SEED_LSB +: SEED_W];
            tag_q  <= st_wdata[TAG_W-1:0];
          end else if (accept) begin
            seed_q  <= seed_step;
            ptr_q   <= req_ptr;
            state_q <= S_WALK;
          end
        end
        S_WALK: begin
          if (w_fin) begin
            tag_q   <= w_tag;
            state_q <= S_HOLD;
          end
        end
        S_HOLD: begin
          if (res_ready) state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign res_valid = (state_q == S_HOLD);
  assign res_ptr   = (ptr_q & ~TAG_MASK) | ({{(PTR_W-TAG_W){1'b0}}, tag_q} << TAG_LSB);
  assign st_rdata  = {seed_q, {PAD_W{1'b0}}, tag_q};
endmodule

// File: rtl/tag_rand_gen_chk.sv
module tag_rand_gen_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        rnd_en,
  input logic        res_valid,
  input logic        res_ready,
  input logic [63:0] res_ptr,
  input logic        st_wr,
  input logic [23:0] st_wdata,
  input logic [23:0] st_rdata,
  input logic [1:0]  state_q
);
  // R10: no request is taken while a result waits
  p_ready_low_on_result_r10: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !req_ready);

  // R10: held result does not change or vanish
  p_result_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_ptr));

  // R7 / R9: tag in pointer agrees with tag in state
  p_tag_agrees_r7: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> st_rdata[3:0] == res_ptr[59:56]);

  // R8: random mode never leaves a zero seed after stepping
  p_seed_nonzero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && rnd_en |=> st_rdata[23:8] != 16'h0);

  // R11: a state write blocks request acceptance
  p_write_blocks_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
    st_wr |-> !req_ready);

  // R11: idle write lands in the state
  p_write_loads_r11: assert property (@(posedge clk) disable iff (!rst_n)
    st_wr && state_q == 2'd0 |=> st_rdata == {$past(st_wdata[23:8]), 4'h0, $past(st_wdata[3:0])});
endmodule

bind tag_rand_gen tag_rand_gen_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rnd_en    (rnd_en),
  .res_valid (res_valid),
  .res_ready (res_ready),
  .res_ptr   (res_ptr),
  .st_wr     (st_wr),
  .st_wdata  (st_wdata),
  .st_rdata  (st_rdata),
  .state_q   (state_q)
);

// File: tb/test_tag_rand_gen.sv
`timescale 1ns/1ps
module test_tag_rand_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_ptr = '0;
  logic [15:0] req_excl = '0;
  logic [15:0] cfg_excl = '0;
  logic        rnd_en = 1'b0;
  logic        res_valid;
  logic        res_ready = 1'b0;
  logic [63:0] res_ptr;
  logic        st_wr = 1'b0;
  logic [23:0] st_wdata = '0;
  logic [23:0] st_rdata;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  logic [15:0] m_seed;
  logic [3:0]  m_tag;

  always #2 clk = ~clk;

  tag_rand_gen i_tag_rand_gen (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_ptr(req_ptr), .req_excl(req_excl), .cfg_excl(cfg_excl), .rnd_en(rnd_en),
    .res_valid(res_valid), .res_ready(res_ready), .res_ptr(res_ptr),
    .st_wr(st_wr), .st_wdata(st_wdata), .st_rdata(st_rdata)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      fails = fails + 1;
      tests = tests + 1;
      $display("FAIL watchdog act=%0d exp=<150000", cyc);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] ref_tag(input logic [3:0] start, input logic [3:0] off,
                                         input logic [15:0] ex);
    logic [3:0] t = start;
    if (ex == 16'hFFFF) return 4'h0;
    if (off == 0) begin
      while (ex[t]) t = t + 1'b1;
    end else begin
      for (int k = 0; k < off; k++) begin
        t = t + 1'b1;
        while (ex[t]) t = t + 1'b1;
      end
    end
    return t;
  endfunction

  task automatic write_state(input logic [15:0] sd, input logic [3:0] tg);
    @(negedge clk);
    st_wr = 1'b1;
    st_wdata = {sd, 4'h0, tg};
    @(negedge clk);
    st_wr = 1'b0;
    m_seed = sd;
    m_tag = tg;
    chk("R11", {40'h0, st_rdata}, {40'h0, sd, 4'h0, tg});
  endtask

  task automatic do_req(input string lbl, input logic [63:0] ptr, input logic [15:0] op,
                        input logic [15:0] cf, input logic rnd, input int hold, input bit busy_wr);
    logic [15:0] s;
    logic [3:0]  off;
    logic        fb;
    logic [3:0]  t;
    logic [63:0] exp_ptr;
    logic [63:0] held;
    int          wait_n;
    s = (rnd && m_seed == 16'h0) ? 16'h0001 : m_seed;
    off = '0;
    for (int i = 0; i < 4; i++) begin
      fb = s[5] ^ s[3] ^ s[2] ^ s[0];
      s = {fb, s[15:1]};
      off[i] = fb;
    end
    t = ref_tag(m_tag, off, op | cf);
    m_seed = s;
    m_tag = t;
    exp_ptr = ptr;
    exp_ptr[59:56] = t;

    @(negedge clk);
    chk("R10", {63'h0, req_ready}, 64'h1);
    req_valid = 1'b1; req_ptr = ptr; req_excl = op; cfg_excl = cf; rnd_en = rnd;
    @(negedge clk);
    req_valid = 1'b0; req_excl = $urandom; cfg_excl = $urandom; req_ptr = {$urandom, $urandom};
    if (busy_wr) begin
      st_wr = 1'b1; st_wdata = {$urandom} [23:0];
      @(negedge clk);
      st_wr = 1'b0;
    end
    wait_n = 0;
    while (!res_valid && wait_n < 1000) begin
      @(negedge clk);
      wait_n++;
    end
    chk(lbl, {60'h0, res_ptr[59:56]}, {60'h0, t});
    chk("R9", res_ptr, exp_ptr);
    chk("R7", {40'h0, st_rdata}, {40'h0, s, 4'h0, t});
    held = res_ptr;
    for (int h = 0; h < hold; h++) begin
      if (busy_wr) begin st_wr = 1'b1; st_wdata = {$urandom} [23:0]; end
      @(negedge clk);
      st_wr = 1'b0;
      chk("R10", {62'h0, res_valid, req_ready}, 64'h2);
      chk("R10", res_ptr, held);
    end
    chk("R11", {40'h0, st_rdata}, {40'h0, s, 4'h0, t});
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
    chk("R10", {63'h0, res_valid}, 64'h0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    m_seed = 16'h0001;
    m_tag = 4'h0;
    chk("R1", {61'h0, req_ready, res_valid, 1'b0}, 64'h4);
    chk("R1", {40'h0, st_rdata}, 64'h000100);

    // R4: from reset seed, no exclusion
    do_req("R4", 64'h0123_4567_89AB_CDEF, 16'h0, 16'h0, 1'b0, 0, 1'b0);
    // R7: chained request starts from last tag
    do_req("R7", 64'hFFFF_0000_FFFF_0000, 16'h0, 16'h0, 1'b0, 1, 1'b0);

    // R5: zero seed, random off -> offset 0, skip 5 and 6
    write_state(16'h0000, 4'h5);
    do_req("R5", 64'h0F00_0000_0000_1234, 16'h0020, 16'h0040, 1'b0, 0, 1'b0);
    chk("R8", {48'h0, st_rdata[23:8]}, 64'h0);
    // R5: start allowed -> kept
    do_req("R5", 64'h1, 16'hFF7F, 16'h0000, 1'b0, 0, 1'b0);

    // R3 / R2: all excluded only when masks combine
    write_state(16'hACE1, 4'h9);
    do_req("R3", 64'hAAAA_5555_AAAA_5555, 16'hFF00, 16'h00FF, 1'b1, 0, 1'b0);
    do_req("R2", 64'h2, 16'hFF00, 16'h00F7, 1'b0, 0, 1'b0);

    // R8: zero seed with random on -> fallback seed used
    write_state(16'h0000, 4'h2);
    do_req("R8", 64'h3, 16'h0, 16'h0, 1'b1, 0, 1'b0);

    // R11: write and request in the same idle cycle
    @(negedge clk);
    st_wr = 1'b1; st_wdata = {16'h1234, 4'h0, 4'hC}; req_valid = 1'b1;
    #0.5 chk("R11", {63'h0, req_ready}, 64'h0);
    @(negedge clk);
    st_wr = 1'b0; req_valid = 1'b0;
    m_seed = 16'h1234; m_tag = 4'hC;
    chk("R11", {40'h0, st_rdata}, {40'h0, 16'h1234, 4'h0, 4'hC});
    repeat (4) @(negedge clk);
    chk("R11", {63'h0, res_valid}, 64'h0);
    // R11: writes while busy are ignored
    do_req("R11", 64'h4444, 16'h0101, 16'h0, 1'b0, 2, 1'b1);

    // R6: random requests
    for (int n = 0; n < 80; n++) begin
      logic [15:0] op;
      logic [15:0] cf;
      int sel = $urandom_range(0, 7);
      op = $urandom; cf = $urandom;
      if (sel == 0) begin op = '0; cf = '0; end
      else if (sel == 1) begin op = ~(16'h1 << $urandom_range(0, 15)); cf = '0; end
      else if (sel < 5) begin op = op & $urandom; cf = cf & $urandom & $urandom; end
      if ($urandom_range(0, 9) == 0) write_state($urandom_range(0, 3) == 0 ? 16'h0 : 16'($urandom),
                                                 4'($urandom));
      do_req("R6", {$urandom, $urandom}, op, cf, 1'($urandom), $urandom_range(0, 3),
             $urandom_range(0, 7) == 0);
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule